// File: doc/BRIEF.md
# Region Bus-Width and Byte-Strobe Unit

This unit sits between a 16-bit processor core and an external memory bus. For every access the core starts, it decides whether the external data bus is 8 or 16 bits wide. It bases that choice on which chip-select region the address falls in and on a small set of size configuration bits. It then drives the active-low write-high-byte, write-low-byte and read strobes, together with the address bit 0 and byte-high-enable that go out with them.

A 16-bit word access to a region configured as 8 bits wide is carried out as two byte cycles, with the low byte first. Completion is signalled to the core only after the second byte cycle. The core pulses `req_i` with the access attributes. It then waits for `done_o`.

The size state has four parts:
- The upper boot region takes its initial width from a pin sampled during reset. Software may widen it later but can never narrow it.
- The mid-range memory, peripheral memory and unmapped memory regions share one size bit.
- I/O space has its own size bit.
- The on-chip control-block region is always 16 bits wide.

The width is sampled when a cycle starts. A configuration write made during a cycle therefore takes effect only from the next cycle.

The controller has four states:
- ST_IDLE: no bus cycle is running.
- ST_SINGLE: a single bus cycle.
- ST_LOW_HALF: the first byte of a split word.
- ST_HIGH_HALF: the second byte of a split word.

Its transitions are:
- ST_IDLE to ST_LOW_HALF, on a request for a word access (`a0_i`=0, `bhe_n_i`=0) in a region that is 8 bits wide.
- ST_IDLE to ST_SINGLE, on any other request.
- ST_LOW_HALF to ST_HIGH_HALF, always.
- ST_SINGLE to ST_IDLE and ST_HIGH_HALF to ST_IDLE, always. Each of these states lasts one clock.

Top module: `bus_width_unit`

## Requirements
- R1: During reset the upper boot region width is loaded from `boot_wide_i`: 0 gives 8-bit (`wide_o`=0), 1 gives 16-bit (`wide_o`=1).
- R2: A size write to the boot region (`cfg_sel_i`=0) with `cfg_val_i`=0 makes it 16-bit. A write with `cfg_val_i`=1 never turns a 16-bit boot region into 8-bit, and leaves an 8-bit one at 8-bit.
- R3: The mid-range (`region_hit_i` bit 1), peripheral memory (bit 2) and no-hit memory accesses share one size bit, written with `cfg_sel_i`=1. Its reset value is 0, meaning 16-bit, and 1 selects 8-bit.
- R4: I/O accesses (`io_i`=1) use a separate size bit written with `cfg_sel_i`=2. Its reset value is 0 (16-bit), and 1 selects 8-bit. This bit does not affect memory regions.
- R5: An access hitting the control-block region (`region_hit_i` bit 3) is always 16-bit, whatever the size bits say and whether it is memory or I/O.
- R6: `whb_n_o` is low only in a write cycle with `bhe_n_o` low. In every write cycle with `bhe_n_o` low it is low.
- R7: `wlb_n_o` is low only in a write cycle with `addr0_o` low. In every write cycle with `addr0_o` low it is low.
- R8: `rd_n_o` is low throughout every read cycle, byte or word, and high during write cycles.
- R9: A word access to an 8-bit region takes two cycles. The first has `addr0_o`=0, `bhe_n_o`=1 and `done_o`=0. The second has `addr0_o`=1, `bhe_n_o`=0, `lane_swap_o`=1 and `done_o`=1.
- R10: Any other access takes one cycle with `done_o`=1, and `addr0_o`/`bhe_n_o` follow the request. `lane_swap_o` is 1 only for an odd-address byte in an 8-bit region.
- R11: A size write issued while a cycle is in progress does not change `wide_o` for that cycle. It applies from the next cycle.
- R12: While idle, and out of reset, all three strobes are high and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_wide_i | input | 1 | Boot width pin, sampled in reset (1 = 16-bit) |
| cfg_wr_i | input | 1 | Size bit write strobe |
| cfg_sel_i | input | 2 | Size bit select: 0 boot, 1 memory, 2 I/O |
| cfg_val_i | input | 1 | Size bit value (1 = 8-bit) |
| region_hit_i | input | 4 | One-hot region hit: 0 boot, 1 mid-range, 2 peripheral memory, 3 control block |
| io_i | input | 1 | Access is to I/O space |
| req_i | input | 1 | Start pulse for an access |
| a0_i | input | 1 | Address bit 0 of the request |
| bhe_n_i | input | 1 | Active-low byte-high-enable of the request |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_o | output | 1 | Width of the current cycle (1 = 16-bit) |
| addr0_o | output | 1 | Address bit 0 driven on the bus |
| bhe_n_o | output | 1 | Byte-high-enable driven on the bus |
| whb_n_o | output | 1 | Active-low write-high-byte strobe |
| wlb_n_o | output | 1 | Active-low write-low-byte strobe |
| rd_n_o | output | 1 | Active-low read strobe / output enable |
| lane_swap_o | output | 1 | Move the high byte onto the low data lane |
| done_o | output | 1 | Access complete |

## Verification
On every cycle, the assertions check four things:
- The strobe relations against the driven `addr0_o`/`bhe_n_o`.
- That reads and writes are mutually exclusive.
- That the idle outputs are quiet.
- That the split sequence runs from the low half to the high half, with a stable width and a single-cycle done.

Only the bench's scenarios can show the width each region and size-bit combination yields. The same holds for the reset capture of the boot pin, the one-way widening of the boot region, and the deferral of a size write made mid-cycle.

// File: rtl/bwu_pkg.sv
package bwu_pkg;
    localparam int NUM_REGIONS = 4;
    localparam int REG_BOOT    = 0;
    localparam int REG_MID     = 1;
    localparam int REG_PMEM    = 2;
    localparam int REG_CTRL    = 3;

    localparam int CFG_SEL_W   = 2;
    localparam int CFG_BOOT    = 0;
    localparam int CFG_MEM     = 1;
    localparam int CFG_IO      = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SINGLE    = 2'd1,
        ST_LOW_HALF  = 2'd2,
        ST_HIGH_HALF = 2'd3
    } bwu_state_e;

    typedef struct packed {
        logic a0;
        logic bhe_n;
        logic we;
        logic wide;
    } bwu_req_t;
endpackage

// File: rtl/bwu_size_regs.sv
module bwu_size_regs
    import bwu_pkg::*;
#(
    parameter int SEL_W = CFG_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_wide_i,
    input  logic             cfg_wr_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             cfg_val_i,
    output logic             boot_narrow_o,
    output logic             mem_narrow_o,
    output logic             io_narrow_o
);
    localparam logic [SEL_W-1:0] SEL_BOOT = SEL_W'(CFG_BOOT);
    localparam logic [SEL_W-1:0] SEL_MEM  = SEL_W'(CFG_MEM);
    localparam logic [SEL_W-1:0] SEL_IO   = SEL_W'(CFG_IO);

    logic boot_narrow_q, mem_narrow_q, io_narrow_q;

    // Boot width: loaded from the pin in reset, may only go from narrow to wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_narrow_q <= ~boot_wide_i;
        end else if (cfg_wr_i && cfg_sel_i == SEL_BOOT) begin
            boot_narrow_q <= boot_narrow_q & cfg_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_narrow_q <= 1'b0;
            io_narrow_q  <= 1'b0;
        end else if (cfg_wr_i) begin
            if (cfg_sel_i == SEL_MEM) mem_narrow_q <= cfg_val_i;
            if (cfg_sel_i == SEL_IO)  io_narrow_q  <= cfg_val_i;
        end
    end

    assign boot_narrow_o = boot_narrow_q;
    assign mem_narrow_o  = mem_narrow_q;
    assign io_narrow_o   = io_narrow_q;
endmodule

// File: rtl/bwu_width_sel.sv
module bwu_width_sel
    import bwu_pkg::*;
#(
    parameter int NREG = NUM_REGIONS
) (
    input  logic [NREG-1:0] region_hit_i,
    input  logic            io_i,
    input  logic            boot_narrow_i,
    input  logic            mem_narrow_i,
    input  logic            io_narrow_i,
    output logic            wide_o
);
    logic mem_space;
    assign mem_space = region_hit_i[REG_MID] | region_hit_i[REG_PMEM] | ~|region_hit_i;

    // Control block first, then I/O, then boot region, then shared memory bit.
    always_comb begin
        if (region_hit_i[REG_CTRL])      wide_o = 1'b1;
        else if (io_i)                   wide_o = ~io_narrow_i;
        else if (region_hit_i[REG_BOOT]) wide_o = ~boot_narrow_i;
        else if (mem_space)              wide_o = ~mem_narrow_i;
        else                             wide_o = 1'b1;
    end
endmodule

// File: rtl/bwu_cycle_fsm.sv
module bwu_cycle_fsm
    import bwu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       a0_i,
    input  logic       bhe_n_i,
    input  logic       we_i,
    input  logic       wide_i,
    output logic       wide_o,
    output logic       addr0_o,
    output logic       bhe_n_o,
    output logic       whb_n_o,
    output logic       wlb_n_o,
    output logic       rd_n_o,
    output logic       lane_swap_o,
    output logic       done_o,
    output bwu_state_e state_o
);
    bwu_state_e state_q, state_d;
    bwu_req_t   cap_q;
    logic       split_req;

    assign split_req = ~a0_i & ~bhe_n_i & ~wide_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_i) state_d = split_req ? ST_LOW_HALF : ST_SINGLE;
            ST_SINGLE:    state_d = ST_IDLE;
            ST_LOW_HALF:  state_d = ST_HIGH_HALF;
            ST_HIGH_HALF: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register; request attributes and width are frozen at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '{a0: 1'b0, bhe_n: 1'b1, we: 1'b0, wide: 1'b1};
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_i)
                cap_q <= '{a0: a0_i, bhe_n: bhe_n_i, we: we_i, wide: wide_i};
        end
    end

    always_comb begin
        wide_o      = cap_q.wide;
        addr0_o     = cap_q.a0;
        bhe_n_o     = cap_q.bhe_n;
        whb_n_o     = 1'b1;
        wlb_n_o     = 1'b1;
        rd_n_o      = 1'b1;
        lane_swap_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SINGLE: begin
                whb_n_o     = cap_q.bhe_n | ~cap_q.we;
                wlb_n_o     = cap_q.a0 | ~cap_q.we;
                rd_n_o      = cap_q.we;
                lane_swap_o = ~cap_q.wide & cap_q.a0;
                done_o      = 1'b1;
            end
            ST_LOW_HALF: begin
                addr0_o = 1'b0;
                bhe_n_o = 1'b1;
                wlb_n_o = ~cap_q.we;
                rd_n_o  = cap_q.we;
            end
            ST_HIGH_HALF: begin
                addr0_o     = 1'b1;
                bhe_n_o     = 1'b0;
                whb_n_o     = ~cap_q.we;
                rd_n_o      = cap_q.we;
                lane_swap_o = 1'b1;
                done_o      = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/bus_width_unit.sv
module bus_width_unit
    import bwu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boot_wide_i,
    input  logic                   cfg_wr_i,
    input  logic [CFG_SEL_W-1:0]   cfg_sel_i,
    input  logic                   cfg_val_i,
    input  logic [NUM_REGIONS-1:0] region_hit_i,
    input  logic                   io_i,
    input  logic                   req_i,
    input  logic                   a0_i,
    input  logic                   bhe_n_i,
    input  logic                   we_i,
    output logic                   wide_o,
    output logic                   addr0_o,
    output logic                   bhe_n_o,
    output logic                   whb_n_o,
    output logic                   wlb_n_o,
    output logic                   rd_n_o,
    output logic                   lane_swap_o,
    output logic                   done_o
);
    logic       boot_narrow, mem_narrow, io_narrow, wide_sel;
    bwu_state_e fsm_state;

    bwu_size_regs #(.SEL_W(CFG_SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_wide_i(boot_wide_i),
        .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i), .cfg_val_i(cfg_val_i),
        .boot_narrow_o(boot_narrow), .mem_narrow_o(mem_narrow), .io_narrow_o(io_narrow)
    );

    bwu_width_sel #(.NREG(NUM_REGIONS)) u_sel (
        .region_hit_i(region_hit_i), .io_i(io_i),
        .boot_narrow_i(boot_narrow), .mem_narrow_i(mem_narrow), .io_narrow_i(io_narrow),
        .wide_o(wide_sel)
    );

    bwu_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .a0_i(a0_i), .bhe_n_i(bhe_n_i),
        .we_i(we_i), .wide_i(wide_sel), .wide_o(wide_o), .addr0_o(addr0_o),
        .bhe_n_o(bhe_n_o), .whb_n_o(whb_n_o), .wlb_n_o(wlb_n_o), .rd_n_o(rd_n_o),
        .lane_swap_o(lane_swap_o), .done_o(done_o), .state_o(fsm_state)
    );
endmodule

// File: rtl/bwu_checker.sv
module bwu_checker
    import bwu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bwu_state_e state,
    input logic       wide_o,
    input logic       addr0_o,
    input logic       bhe_n_o,
    input logic       whb_n_o,
    input logic       wlb_n_o,
    input logic       rd_n_o,
    input logic       lane_swap_o,
    input logic       done_o
);
    assert_whb_needs_bhe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !whb_n_o |-> (!bhe_n_o && rd_n_o));

    assert_wlb_needs_a0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wlb_n_o |-> (!addr0_o && rd_n_o));

    assert_read_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (whb_n_o && wlb_n_o));

    assert_split_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW_HALF) |=> (state == ST_HIGH_HALF));

    assert_high_half_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH_HALF) |-> (addr0_o && !bhe_n_o && lane_swap_o && done_o));

    assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_width_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH_HALF) |-> $stable(wide_o));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (whb_n_o && wlb_n_o && rd_n_o && !done_o));
endmodule

bind bus_width_unit bwu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(fsm_state), .wide_o(wide_o),
    .addr0_o(addr0_o), .bhe_n_o(bhe_n_o), .whb_n_o(whb_n_o), .wlb_n_o(wlb_n_o),
    .rd_n_o(rd_n_o), .lane_swap_o(lane_swap_o), .done_o(done_o)
);

// File: tb/bus_width_unit_test.sv
module bus_width_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_wide = 1'b1;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic cfg_val = 1'b0;
    logic [3:0] hit = 4'd0;
    logic io = 1'b0, req = 1'b0, a0 = 1'b0, bhe_n = 1'b1, we = 1'b0;
    logic wide, addr0, bhe_o, whb_n, wlb_n, rd_n, swap, done;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_width_unit uut (
        .clk(clk), .rst_n(rst_n), .boot_wide_i(boot_wide), .cfg_wr_i(cfg_wr),
        .cfg_sel_i(cfg_sel), .cfg_val_i(cfg_val), .region_hit_i(hit), .io_i(io),
        .req_i(req), .a0_i(a0), .bhe_n_i(bhe_n), .we_i(we), .wide_o(wide),
        .addr0_o(addr0), .bhe_n_o(bhe_o), .whb_n_o(whb_n), .wlb_n_o(wlb_n),
        .rd_n_o(rd_n), .lane_swap_o(swap), .done_o(done)
    );

    typedef struct packed {
        logic [3:0] hit;
        logic io;
        logic a0;
        logic bhe_n;
        logic we;
        logic wide;
        logic split;
    } vec_t;

    // Default size state, boot pin high: every region is 16-bit.
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 mid word write
        '{4'b0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 mid low byte read
        '{4'b0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 pmem high byte write
        '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 unmapped word read
        '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 io word write
        '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 boot word read
        '{4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 ctrl word write
        '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}   // R7 io odd byte read
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic act, input logic exp);
        check(act === exp, tag, int'(act), int'(exp));
    endtask

    task automatic chk_idle(input string tag);
        chk_eq({tag, " R12 whb"}, whb_n, 1'b1);
        chk_eq({tag, " R12 wlb"}, wlb_n, 1'b1);
        chk_eq({tag, " R12 rd"}, rd_n, 1'b1);
        chk_eq({tag, " R12 done"}, done, 1'b0);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_val = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; boot_wide = pin;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        boot_wide = ~pin;
    endtask

    // Drives one request pulse and checks every cycle up to the return to idle.
    task automatic do_access(input vec_t v, input string tag);
        @(negedge clk);
        req = 1'b1; hit = v.hit; io = v.io; a0 = v.a0; bhe_n = v.bhe_n; we = v.we;
        @(negedge clk);
        req = 1'b0; a0 = ~v.a0; bhe_n = ~v.bhe_n; we = ~v.we;
        chk_eq({tag, " width"}, wide, v.wide);
        if (!v.split) begin
            chk_eq({tag, " R10 done"}, done, 1'b1);
            chk_eq({tag, " R10 addr0"}, addr0, v.a0);
            chk_eq({tag, " R10 bhe"}, bhe_o, v.bhe_n);
            chk_eq({tag, " R6 whb"}, whb_n, ~(v.we & ~v.bhe_n));
            chk_eq({tag, " R7 wlb"}, wlb_n, ~(v.we & ~v.a0));
            chk_eq({tag, " R8 rd"}, rd_n, v.we);
            chk_eq({tag, " R10 swap"}, swap, ~v.wide & v.a0);
        end else begin
            chk_eq({tag, " R9 first done"}, done, 1'b0);
            chk_eq({tag, " R9 first addr0"}, addr0, 1'b0);
            chk_eq({tag, " R9 first bhe"}, bhe_o, 1'b1);
            chk_eq({tag, " R7 first wlb"}, wlb_n, ~v.we);
            chk_eq({tag, " R6 first whb"}, whb_n, 1'b1);
            chk_eq({tag, " R8 first rd"}, rd_n, v.we);
            @(negedge clk);
            chk_eq({tag, " R9 second done"}, done, 1'b1);
            chk_eq({tag, " R9 second addr0"}, addr0, 1'b1);
            chk_eq({tag, " R9 second bhe"}, bhe_o, 1'b0);
            chk_eq({tag, " R9 second swap"}, swap, 1'b1);
            chk_eq({tag, " R6 second whb"}, whb_n, ~v.we);
            chk_eq({tag, " R8 second rd"}, rd_n, v.we);
            chk_eq({tag, " R11 width kept"}, wide, v.wide);
        end
        @(negedge clk);
        chk_idle(tag);
    endtask

    initial begin
        do_reset(1'b1);
        chk_idle("reset");

        for (int i = 0; i < NVEC; i++) do_access(VECS[i], $sformatf("vec%0d", i));

        // R3: memory regions become 8-bit together, I/O and control block unaffected.
        cfg_write(2'd1, 1'b1);
        do_access('{4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, "R3 mid split write");
        do_access('{4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R3 unmapped split read");
        do_access('{4'b0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, "R10 narrow odd byte");
        do_access('{4'b0100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, "R10 narrow even byte");
        do_access('{4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, "R5 ctrl mem");
        do_access('{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R4 io unaffected");
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R1 boot unaffected");

        // R4: I/O bit.
        cfg_write(2'd2, 1'b1);
        do_access('{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R4 io split read");
        do_access('{4'b1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, "R5 ctrl io");

        // R11: size write during a split cycle is deferred.
        @(negedge clk);
        req = 1'b1; hit = 4'b0010; io = 1'b0; a0 = 1'b0; bhe_n = 1'b0; we = 1'b1;
        @(negedge clk);
        req = 1'b0; cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_val = 1'b0;
        chk_eq("R11 first half width", wide, 1'b0);
        chk_eq("R11 first half done", done, 1'b0);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk_eq("R11 second half width", wide, 1'b0);
        chk_eq("R11 second half done", done, 1'b1);
        @(negedge clk);
        chk_idle("R11 end");
        do_access('{4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, "R11 next cycle wide");

        // R1/R2: boot width from pin low, one-way widening.
        do_reset(1'b0);
        chk_idle("reset2");
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R1 boot narrow");
        cfg_write(2'd0, 1'b1);
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, "R2 boot stays narrow");
        cfg_write(2'd0, 1'b0);
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, "R2 boot widened");
        cfg_write(2'd0, 1'b1);
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R2 no renarrow");
        do_reset(1'b1);
        cfg_write(2'd0, 1'b1);
        do_access('{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R2 wide boot locked");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule